// File: doc/BRIEF.md
# Transactional Cache Access Tracker

A small direct-mapped data cache for one core that runs hardware transactions. Each line holds one data word, a tag, valid and dirty flags, and two tracking flags: one marks lines the open transaction has loaded, the other marks lines it has stored to. Stores made inside a transaction stay in the cache. Remote read and write addresses seen on a shared bus are compared against the tracked lines. When the two collide, the local transaction is cancelled and the core is told to roll back to its saved register state.

The register checkpoint is represented by a flag that is set while a snapshot is held, plus a one-cycle restore request. A miss that would have to evict a tracked line raises an overflow pulse and performs no access, so tracking is never lost. Interrupts that cannot wait cancel a transaction only while it is still young. The age limit is a programmable cycle count. A miss fills from the `fill_data` input in the same cycle. Dirty lines leave the cache only through the write-back outputs.

Top module: `txn_track_cache`

## Requirements
- R1: After reset `in_tx`, `ckpt_valid`, `abort`, `restore`, `commit`, `overflow`, `rsp_valid` and `wb_valid` are all 0, and every line is invalid.
- R2: `tx_begin` while no transaction is open sets `in_tx` and `ckpt_valid` on the next cycle. `tx_begin` inside a transaction is ignored, so there is no nesting.
- R3: Inside a transaction a load marks its line as read and a store marks its line as written. Outside a transaction neither mark is ever set.
- R4: Inside a transaction these cases are conflicts: a remote write whose address hits a valid line marked read or written, and a remote read that hits a line marked written. A remote read of a line that is only marked read is not a conflict. A remote access whose tag differs from the line at that index is not a conflict.
- R5: A conflict pulses `abort` and `restore` for one cycle, one cycle later. It also clears `in_tx` and `ckpt_valid`, invalidates every line marked written, and clears all marks. Lines marked only read keep their data and still hit. A core access in the conflict cycle is dropped.
- R6: Speculative data is never written back. When a transactional store hits a dirty line not yet marked written, the old committed word is emitted on `wb_valid`/`wb_addr`/`wb_data` on the next cycle, before it is overwritten.
- R7: Inside a transaction, a miss whose victim line is marked read or written pulses `overflow` on the next cycle. In that case `rsp_valid` is 0, there is no write-back, the victim line is kept, and the transaction stays open.
- R8: `tx_end` inside a transaction with no conflict pulses `commit` on the next cycle. It clears `in_tx` and `ckpt_valid` and clears all marks in that one cycle. The stored words remain as valid dirty lines.
- R9: When a conflict and `tx_end` fall in the same cycle, the abort is taken and `commit` stays 0.
- R10: The transaction age is 0 in the first cycle after begin and rises by one each cycle. An interrupt request with `irq_can_wait`=0 aborts the transaction while age < `young_limit`. With `irq_can_wait`=1, or once the transaction is old, the interrupt does not abort. `irq_grant` is `irq_req` while no transaction is open.
- R11: Outside a transaction, remote accesses and `tx_end` never cause `abort` or `commit`.
- R12: A core request produces `rsp_valid` on the next cycle. On that cycle `rsp_hit` shows whether the tag matched, and `rsp_data` is the line word for a load hit or `fill_data` for a load miss. A miss whose victim is valid and dirty writes back the victim on the same cycle, with address {tag, index}; the index is the low `IDX_W` address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core access request |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | ADDR_W | Word address |
| core_wdata | input | DATA_W | Store data |
| fill_data | input | DATA_W | Memory word for a miss, same cycle |
| tx_begin | input | 1 | Open a transaction |
| tx_end | input | 1 | Request commit |
| irq_req | input | 1 | Pending interrupt |
| irq_can_wait | input | 1 | Interrupt tolerates waiting for commit |
| young_limit | input | AGE_W | Age below which a transaction is young |
| snp_valid | input | 1 | Remote bus access present |
| snp_we | input | 1 | Remote access is a write |
| snp_addr | input | ADDR_W | Remote access address |
| rsp_valid | output | 1 | Access response |
| rsp_hit | output | 1 | Response was a hit |
| rsp_data | output | DATA_W | Response data |
| wb_valid | output | 1 | Dirty word leaving the cache |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | DATA_W | Write-back data |
| overflow | output | 1 | Tracked-line eviction refused |
| abort | output | 1 | Transaction cancelled |
| restore | output | 1 | Core must roll back to checkpoint |
| commit | output | 1 | Transaction committed |
| in_tx | output | 1 | Transaction open |
| ckpt_valid | output | 1 | Register snapshot held |
| irq_grant | output | 1 | Interrupt may be taken now |

## Verification
The hardest situations to reach from the ports involve timing and prior line state. One is a conflict that lands in the same cycle as `tx_end`. Another is an interrupt whose outcome depends on the transaction's age. A third is a transactional store onto a line that was already dirty from committed work. The bench reaches these with short directed sequences. It first places a line in a known state with plain accesses outside any transaction. It then opens a transaction and drives the snoop, interrupt or end inputs on the exact cycle it chooses. It counts idle cycles to set the age. The effect of tracking marks is read back only through later snoops, loads that hit or miss, and write-backs.

// File: rtl/txc_pkg.sv
package txc_pkg;

  // Conflict rule for a remote access that hits a valid line
  function automatic logic remote_collides(input logic remote_we,
                                           input logic rd_mark,
                                           input logic wr_mark);
    return remote_we ? (rd_mark | wr_mark) : wr_mark;
  endfunction

  // Age test, operands zero-extended by the caller
  function automatic logic still_young(input logic [31:0] age,
                                       input logic [31:0] limit);
    return age < limit;
  endfunction

endpackage

// File: rtl/txc_lines.sv
module txc_lines #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              in_tx,
  input  logic              commit_clr,
  input  logic              abort_clr,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_rd,
  output logic              snp_wr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              overflow
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [LINES-1:0]  vld_q, drt_q, rdm_q, wrm_q;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  logic [IDX_W-1:0] idx, s_idx;
  logic [TAG_W-1:0] tg, s_tg;
  logic hit, victim_tracked, ovf_now, do_acc, wb_now;

  assign idx   = acc_addr[IDX_W-1:0];
  assign tg    = acc_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tg  = snp_addr[ADDR_W-1:IDX_W];

  assign hit            = vld_q[idx] && (tag_q[idx] == tg);
  assign victim_tracked = vld_q[idx] && (rdm_q[idx] || wrm_q[idx]);
  assign ovf_now        = acc_en && in_tx && !hit && victim_tracked;
  assign do_acc         = acc_en && !ovf_now;
  // dirty victim on a miss, or committed word about to be overwritten speculatively
  assign wb_now = do_acc && vld_q[idx] && drt_q[idx] &&
                  (!hit || (acc_we && in_tx && !wrm_q[idx]));

  assign snp_hit = vld_q[s_idx] && (tag_q[s_idx] == s_tg);
  assign snp_rd  = rdm_q[s_idx];
  assign snp_wr  = wrm_q[s_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= '0;
      drt_q     <= '0;
      rdm_q     <= '0;
      wrm_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
      overflow  <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      rsp_valid <= do_acc;
      overflow  <= ovf_now;
      wb_valid  <= wb_now;
      if (wb_now) begin
        wb_addr <= {tag_q[idx], idx};
        wb_data <= dat_q[idx];
      end
      if (do_acc) begin
        rsp_hit  <= hit;
        rsp_data <= hit ? dat_q[idx] : (acc_we ? acc_wdata : fill_data);
        if (!hit) begin
          vld_q[idx] <= 1'b1;
          tag_q[idx] <= tg;
          drt_q[idx] <= acc_we;
          dat_q[idx] <= acc_we ? acc_wdata : fill_data;
        end else if (acc_we) begin
          drt_q[idx] <= 1'b1;
          dat_q[idx] <= acc_wdata;
        end
        rdm_q[idx] <= (hit & rdm_q[idx]) | (in_tx & ~acc_we);
        wrm_q[idx] <= (hit & wrm_q[idx]) | (in_tx & acc_we);
      end
      if (commit_clr) begin
        rdm_q <= '0;
        wrm_q <= '0;
      end
      if (abort_clr) begin
        vld_q <= vld_q & ~wrm_q;
        rdm_q <= '0;
        wrm_q <= '0;
      end
    end
  end
endmodule

// File: rtl/txc_snoop.sv
module txc_snoop (
  input  logic in_tx,
  input  logic snp_valid,
  input  logic snp_we,
  input  logic snp_hit,
  input  logic snp_rd,
  input  logic snp_wr,
  output logic conflict
);
  import txc_pkg::*;
  assign conflict = in_tx && snp_valid && snp_hit &&
                    remote_collides(snp_we, snp_rd, snp_wr);
endmodule

// File: rtl/txc_txctl.sv
module txc_txctl #(
  parameter int AGE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_begin,
  input  logic             tx_end,
  input  logic             conflict,
  input  logic             irq_req,
  input  logic             irq_can_wait,
  input  logic [AGE_W-1:0] young_limit,
  output logic             in_tx,
  output logic             ckpt_valid,
  output logic             abort_now,
  output logic             commit_now,
  output logic             irq_abort,
  output logic             abort,
  output logic             restore,
  output logic             commit,
  output logic             irq_grant
);
  import txc_pkg::*;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] age_q;
  logic young, begin_now;

  assign young      = in_tx && still_young(32'(age_q), 32'(young_limit));
  assign irq_abort  = in_tx && irq_req && !irq_can_wait && young;
  assign abort_now  = conflict || irq_abort;
  assign commit_now = in_tx && tx_end && !abort_now;
  assign begin_now  = !in_tx && tx_begin;
  assign irq_grant  = irq_req && !in_tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_tx      <= 1'b0;
      ckpt_valid <= 1'b0;
      age_q      <= '0;
      abort      <= 1'b0;
      restore    <= 1'b0;
      commit     <= 1'b0;
    end else begin
      abort   <= abort_now;
      restore <= abort_now && ckpt_valid;
      commit  <= commit_now;
      if (abort_now || commit_now) begin
        in_tx      <= 1'b0;
        ckpt_valid <= 1'b0;
      end else if (begin_now) begin
        in_tx      <= 1'b1;
        ckpt_valid <= 1'b1;
        age_q      <= '0;
      end else if (in_tx && age_q != AGE_MAX) begin
        age_q <= age_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/txn_track_cache.sv
module txn_track_cache #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int AGE_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              tx_begin,
  input  logic              tx_end,
  input  logic              irq_req,
  input  logic              irq_can_wait,
  input  logic [AGE_W-1:0]  young_limit,
  input  logic              snp_valid,
  input  logic              snp_we,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              overflow,
  output logic              abort,
  output logic              restore,
  output logic              commit,
  output logic              in_tx,
  output logic              ckpt_valid,
  output logic              irq_grant
);
  logic snp_hit_w, snp_rd_w, snp_wr_w;
  logic conflict_w, irq_abort_w, abort_now_w, commit_now_w;

  txc_snoop u_snoop (
    .in_tx    (in_tx),
    .snp_valid(snp_valid),
    .snp_we   (snp_we),
    .snp_hit  (snp_hit_w),
    .snp_rd   (snp_rd_w),
    .snp_wr   (snp_wr_w),
    .conflict (conflict_w)
  );

  txc_txctl #(.AGE_W(AGE_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_begin    (tx_begin),
    .tx_end      (tx_end),
    .conflict    (conflict_w),
    .irq_req     (irq_req),
    .irq_can_wait(irq_can_wait),
    .young_limit (young_limit),
    .in_tx       (in_tx),
    .ckpt_valid  (ckpt_valid),
    .abort_now   (abort_now_w),
    .commit_now  (commit_now_w),
    .irq_abort   (irq_abort_w),
    .abort       (abort),
    .restore     (restore),
    .commit      (commit),
    .irq_grant   (irq_grant)
  );

  txc_lines #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (core_req && !abort_now_w),
    .acc_we    (core_we),
    .acc_addr  (core_addr),
    .acc_wdata (core_wdata),
    .fill_data (fill_data),
    .in_tx     (in_tx),
    .commit_clr(commit_now_w),
    .abort_clr (abort_now_w),
    .snp_addr  (snp_addr),
    .snp_hit   (snp_hit_w),
    .snp_rd    (snp_rd_w),
    .snp_wr    (snp_wr_w),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_data  (rsp_data),
    .wb_valid  (wb_valid),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .overflow  (overflow)
  );
endmodule

// File: rtl/txc_checks.sv
module txc_checks (
  input logic clk,
  input logic rst_n,
  input logic in_tx,
  input logic ckpt_valid,
  input logic abort,
  input logic restore,
  input logic commit,
  input logic overflow,
  input logic rsp_valid,
  input logic wb_valid,
  input logic conflict,
  input logic irq_abort
);
  a_r4_conflict_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> abort && !in_tx);

  a_r10_young_irq_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    irq_abort |=> abort);

  a_r11_abort_only_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $past(in_tx));

  a_r9_abort_beats_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort && commit));

  a_r7_overflow_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !rsp_valid && !wb_valid);

  a_r5_restore_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> restore && !ckpt_valid);

  a_r8_commit_closes: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !in_tx && !ckpt_valid);
endmodule

bind txn_track_cache txc_checks u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_tx     (in_tx),
  .ckpt_valid(ckpt_valid),
  .abort     (abort),
  .restore   (restore),
  .commit    (commit),
  .overflow  (overflow),
  .rsp_valid (rsp_valid),
  .wb_valid  (wb_valid),
  .conflict  (conflict_w),
  .irq_abort (irq_abort_w)
);

// File: tb/txn_track_cache_test.sv
module txn_track_cache_test;
  localparam int AW = 10, DW = 16, IW = 3, GW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic core_req = 0, core_we = 0, tx_begin = 0, tx_end = 0;
  logic irq_req = 0, irq_can_wait = 0, snp_valid = 0, snp_we = 0;
  logic [AW-1:0] core_addr = '0, snp_addr = '0;
  logic [DW-1:0] core_wdata = '0, fill_data = '0;
  logic [GW-1:0] young_limit = 12'd4;
  logic rsp_valid, rsp_hit, wb_valid, overflow, abort, restore, commit;
  logic in_tx, ckpt_valid, irq_grant;
  logic [DW-1:0] rsp_data, wb_data;
  logic [AW-1:0] wb_addr;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  txn_track_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .AGE_W(GW)) uut (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .fill_data(fill_data),
    .tx_begin(tx_begin), .tx_end(tx_end), .irq_req(irq_req),
    .irq_can_wait(irq_can_wait), .young_limit(young_limit),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .overflow(overflow), .abort(abort), .restore(restore), .commit(commit),
    .in_tx(in_tx), .ckpt_valid(ckpt_valid), .irq_grant(irq_grant)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear_in();
    core_req = 0; core_we = 0; tx_begin = 0; tx_end = 0;
    snp_valid = 0; snp_we = 0;
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic [DW-1:0] fd);
    core_req = 1; core_we = we; core_addr = a; core_wdata = wd; fill_data = fd;
    step(); clear_in();
  endtask

  task automatic snoop(input logic we, input logic [AW-1:0] a);
    snp_valid = 1; snp_we = we; snp_addr = a;
    step(); clear_in();
  endtask

  task automatic tbegin();
    tx_begin = 1; step(); clear_in();
  endtask

  task automatic tend();
    tx_end = 1; step(); clear_in();
  endtask

  task automatic t_reset();
    check("R1 in_tx", in_tx, 0);
    check("R1 ckpt_valid", ckpt_valid, 0);
    check("R1 pulses", {abort, restore, commit, overflow, rsp_valid, wb_valid}, 0);
    access(0, 10'h005, '0, 16'h7777);
    check("R1 line invalid after reset", rsp_hit, 0);
  endtask

  task automatic t_plain();
    access(1, 10'h010, 16'h00A1, 16'h0000);
    check("R12 store miss response", {rsp_valid, rsp_hit, wb_valid}, 3'b100);
    access(0, 10'h010, '0, 16'h1234);
    check("R12 load hit", {rsp_valid, rsp_hit}, 2'b11);
    check("R12 load hit data", rsp_data, 16'h00A1);
    snoop(1, 10'h010);
    check("R11 remote write outside tx", abort, 0);
    tend();
    check("R11 tx_end outside tx", commit, 0);
    access(0, 10'h018, '0, 16'h5555);
    check("R12 miss fill data", {rsp_hit, rsp_data}, {1'b0, 16'h5555});
    check("R12 dirty victim wb", {wb_valid, wb_addr}, {1'b1, 10'h010});
    check("R12 dirty victim data", wb_data, 16'h00A1);
  endtask

  task automatic t_begin();
    tbegin();
    check("R2 in_tx after begin", {in_tx, ckpt_valid}, 2'b11);
    tbegin();
    check("R2 nested begin ignored", {in_tx, abort}, 2'b10);
    tend();
    check("R8 empty commit", {commit, in_tx, ckpt_valid}, 3'b100);
  endtask

  task automatic t_read_set();
    tbegin();
    access(0, 10'h021, '0, 16'h1111);
    snoop(0, 10'h021);
    check("R4 remote read on read mark", abort, 0);
    snoop(1, 10'h029);
    check("R4 other tag same index", abort, 0);
    snoop(1, 10'h021);
    check("R4 remote write on read mark", {abort, restore, in_tx, ckpt_valid}, 4'b1100);
    access(0, 10'h021, '0, 16'h9999);
    check("R5 read-only line kept", {rsp_hit, rsp_data}, {1'b1, 16'h1111});
    snoop(1, 10'h021);
    check("R3 no mark outside tx", abort, 0);
  endtask

  task automatic t_write_set();
    access(1, 10'h022, 16'hBEEF, '0);
    tbegin();
    access(1, 10'h022, 16'hCAFE, '0);
    check("R6 old word written back", {wb_valid, wb_addr, rsp_hit}, {1'b1, 10'h022, 1'b1});
    check("R6 old word data", wb_data, 16'hBEEF);
    access(1, 10'h022, 16'hD00D, '0);
    check("R6 second spec store no wb", wb_valid, 0);
    snoop(0, 10'h022);
    check("R4 remote read on write mark", {abort, restore}, 2'b11);
    access(0, 10'h022, '0, 16'h0F0F);
    check("R5 written line invalidated", {rsp_hit, rsp_data, wb_valid}, {1'b0, 16'h0F0F, 1'b0});
  endtask

  task automatic t_overflow();
    tbegin();
    access(0, 10'h033, '0, 16'h3333);
    access(0, 10'h03B, '0, 16'h4444);
    check("R7 overflow pulse", {overflow, rsp_valid, wb_valid, in_tx}, 4'b1001);
    step();
    check("R7 overflow one cycle", overflow, 0);
    access(0, 10'h033, '0, 16'h0000);
    check("R7 victim kept", {rsp_hit, rsp_data}, {1'b1, 16'h3333});
    tend();
    check("R8 commit after overflow", commit, 1);
  endtask

  task automatic t_commit();
    tbegin();
    access(1, 10'h044, 16'h4A4A, '0);
    tend();
    check("R8 commit", {commit, in_tx, ckpt_valid, abort}, 4'b1000);
    tbegin();
    snoop(1, 10'h044);
    check("R8 marks cleared", abort, 0);
    tend();
    access(0, 10'h04C, '0, 16'h0001);
    check("R8 committed line dirty", {wb_valid, wb_addr}, {1'b1, 10'h044});
    check("R8 committed data", wb_data, 16'h4A4A);
  endtask

  task automatic t_priority();
    tbegin();
    access(0, 10'h055, '0, 16'h5050);
    tx_end = 1; snp_valid = 1; snp_we = 1; snp_addr = 10'h055;
    step(); clear_in();
    check("R9 abort wins", {abort, commit, in_tx}, 3'b100);
  endtask

  task automatic t_irq();
    young_limit = 12'd4;
    tbegin();
    irq_req = 1; irq_can_wait = 0;
    step();
    check("R10 young irq aborts", {abort, restore, in_tx}, 3'b110);
    check("R10 grant after abort", irq_grant, 1);
    irq_req = 0;
    tbegin();
    irq_req = 1; irq_can_wait = 1;
    step();
    check("R10 waitable irq no abort", {abort, in_tx, irq_grant}, 3'b010);
    tend();
    check("R10 grant after commit", {commit, irq_grant}, 2'b11);
    irq_req = 0; irq_can_wait = 0;
    tbegin();
    for (int i = 0; i < 6; i++) step();
    irq_req = 1;
    step();
    check("R10 old tx not aborted", {abort, in_tx}, 2'b01);
    irq_req = 0;
    tend();
    check("R10 old tx commits", commit, 1);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_plain();
    t_begin();
    t_read_set();
    t_write_set();
    t_overflow();
    t_commit();
    t_priority();
    t_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule